// File: doc/BRIEF.md
# Oversampling Serial Receiver With Per-Character Status Queue

This block receives asynchronous serial characters on an idle-high line. A reference tick arrives at 16 or 8 times the bit rate. A mode input selects 8x operation; otherwise the receiver runs at 16x. A falling level on the line arms the receiver. The start bit is confirmed at its middle, and every later bit is sampled once per bit period at that same mid-bit offset. Word length (5 to 8 data bits) and optional even or odd parity are set by static inputs. The receiver finishes with one stop bit.

Each finished character goes into a 16-entry queue together with four status flags: framing error, parity error, break and overrun. A consumer reads the oldest entry from a show-ahead read port and pops it with a read strobe. The empty and full flags show the queue level. The line passes through a two-stage synchronizer before it reaches the frame state machine.

The frame state machine has six named states:
- IDLE waits for a low line.
- START counts to the start-bit middle. It moves to DATA if the line is still low, or back to IDLE if the low was a glitch.
- DATA samples the data bits. After the last one it moves to PARITY when parity is on, otherwise to STOP.
- PARITY samples the parity bit, then moves to STOP.
- STOP samples the stop bit. A high stop bit returns it to IDLE; a low stop bit sends it to HOLD.
- HOLD waits for the line to go high again, then returns to IDLE.

Top module: `uart_rx_statq`

## Requirements
- R1: While the line stays high, no entry is stored. A low line level starts a frame.
- R2: If the line is high at the start-bit mid-sample, the frame is dropped, the receiver returns to IDLE and nothing is stored.
- R3: The start bit is sampled on the 8th tick when fast_mode=0 (16x) and on the 4th tick when fast_mode=1 (8x). Each later bit is sampled 16 (or 8) ticks after the previous sample. Data bits arrive LSB first.
- R4: word_sel values 0,1,2,3 select 5,6,7,8 data bits. Data bits beyond the selected length read as zero in the entry.
- R5: With par_en=1, a parity bit follows the data. par_odd=0 selects even parity and par_odd=1 selects odd parity. Entry bit 9 is set when the received parity bit does not match.
- R6: Entry bit 8 (framing error) is set when the stop bit is sampled low. The receiver then waits for the line to return high before it accepts a new start.
- R7: Entry bit 10 (break) is set when all data bits, the parity bit (if enabled) and the stop bit are sampled low. A break entry also has bit 8 set.
- R8: The queue holds 16 entries of 12 bits: [7:0] data, [8] framing, [9] parity, [10] break, [11] overrun. rd_data shows the oldest entry. rd_en pops it when the queue is not empty. rx_empty and rx_full report zero and 16 entries.
- R9: A character that completes while the queue is full is discarded. Entry bit 11 is then set on the next stored entry only.
- R10: After reset, rx_empty=1, rx_full=0 and the receiver is in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversampling reference tick, one clock wide |
| fast_mode | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| word_sel | input | 2 | Data bits minus five |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| rd_en | input | 1 | Pop the oldest entry |
| rd_data | output | 12 | Oldest entry (status and data) |
| rx_empty | output | 1 | Queue holds no entry |
| rx_full | output | 1 | Queue holds 16 entries |

## Verification
The bench uses the default parameters: a 16-entry queue and a 16x maximum oversampling ratio. With these, the overrun path is reached by filling the queue with sixteen frames, and both the 16x and the 8x sample points are tested at run time. Some frames hold each data bit at its true value only for three ticks around the expected sample point and invert it elsewhere. Such a frame decodes correctly only if sampling happens at the mid-bit offset for the selected mode. Random frames vary the word length, parity, mode and corrupted parity or stop bits.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic              ovr;
        logic              brk;
        logic              perr;
        logic              ferr;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    localparam int ENTRY_W = $bits(rx_entry_t);
endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxq_frame_fsm.sv
module rxq_frame_fsm
    import rxq_pkg::*;
#(
    parameter int OS_MAX = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line,
    input  logic              tick,
    input  logic              fast_mode,
    input  logic [1:0]        word_sel,
    input  logic              par_en,
    input  logic              par_odd,
    output logic              char_valid,
    output logic [DATA_W-1:0] char_data,
    output logic              char_ferr,
    output logic              char_perr,
    output logic              char_brk
);
    localparam int CW = $clog2(OS_MAX);
    localparam int BW = $clog2(DATA_W);

    rx_state_e         state, state_nx;
    logic [CW-1:0]     tcnt;
    logic [BW-1:0]     bidx;
    logic [DATA_W-1:0] shreg;
    logic              par_acc;
    logic              perr_r;
    logic              zero_acc;

    logic [CW-1:0] full_last, half_last;
    logic          sample, last_bit;

    assign full_last = fast_mode ? CW'(OS_MAX/2 - 1) : CW'(OS_MAX - 1);
    assign half_last = fast_mode ? CW'(OS_MAX/4 - 1) : CW'(OS_MAX/2 - 1);
    assign sample    = tick && (tcnt == ((state == RX_START) ? half_last : full_last));
    assign last_bit  = (bidx == (BW'(4) + BW'(word_sel)));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:   if (!line) state_nx = RX_START;
            RX_START:  if (sample) state_nx = line ? RX_IDLE : RX_DATA;
            RX_DATA:   if (sample && last_bit) state_nx = par_en ? RX_PARITY : RX_STOP;
            RX_PARITY: if (sample) state_nx = RX_STOP;
            RX_STOP:   if (sample) state_nx = line ? RX_IDLE : RX_HOLD;
            RX_HOLD:   if (line) state_nx = RX_IDLE;
            default:   state_nx = RX_IDLE;
        endcase
    end

    // bit timing and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt     <= '0;
            bidx     <= '0;
            shreg    <= '0;
            par_acc  <= 1'b0;
            perr_r   <= 1'b0;
            zero_acc <= 1'b1;
        end else begin
            if (state == RX_IDLE || state == RX_HOLD) tcnt <= '0;
            else if (tick) tcnt <= sample ? '0 : tcnt + CW'(1);

            if (state == RX_IDLE) begin
                bidx     <= '0;
                shreg    <= '0;
                par_acc  <= 1'b0;
                perr_r   <= 1'b0;
                zero_acc <= 1'b1;
            end else if (sample) begin
                if (state == RX_DATA) begin
                    shreg[bidx] <= line;
                    bidx        <= bidx + BW'(1);
                    par_acc     <= par_acc ^ line;
                    zero_acc    <= zero_acc & ~line;
                end
                if (state == RX_PARITY) begin
                    perr_r   <= par_acc ^ line ^ par_odd;
                    zero_acc <= zero_acc & ~line;
                end
            end
        end
    end

    // registered character outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            char_valid <= 1'b0;
            char_data  <= '0;
            char_ferr  <= 1'b0;
            char_perr  <= 1'b0;
            char_brk   <= 1'b0;
        end else begin
            char_valid <= (state == RX_STOP) && sample;
            if ((state == RX_STOP) && sample) begin
                char_data <= shreg;
                char_ferr <= ~line;
                char_perr <= par_en & perr_r;
                char_brk  <= zero_acc & ~line;
            end
        end
    end

    // R7
    brk_implies_ferr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && char_brk) |-> char_ferr);

    // R2
    glitch_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_START && sample && line) |=> (state == RX_IDLE && !char_valid));

    // R6
    hold_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HOLD && !line) |=> (state == RX_HOLD));

    // R1
    idle_line_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && line) |=> (state == RX_IDLE));
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [AW:0]      cnt;
    logic             do_wr, do_rd;

    assign empty   = (cnt == '0);
    assign full    = (cnt == (AW+1)'(DEPTH));
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr <= '0;
            rptr <= '0;
            cnt  <= '0;
        end else begin
            if (do_wr) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + AW'(1);
            if (do_rd) rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + AW'(1);
            cnt <= cnt + (AW+1)'(do_wr) - (AW+1)'(do_rd);
        end
    end

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= (AW+1)'(DEPTH));

    // R8
    flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R9
    write_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full && !rd_en) |=> full && $stable(wptr));
endmodule

// File: rtl/uart_rx_statq.sv
module uart_rx_statq
    import rxq_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int OS_MAX     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rx_in,
    input  logic               os_tick,
    input  logic               fast_mode,
    input  logic [1:0]         word_sel,
    input  logic               par_en,
    input  logic               par_odd,
    input  logic               rd_en,
    output logic [ENTRY_W-1:0] rd_data,
    output logic               rx_empty,
    output logic               rx_full
);
    logic              line_s;
    logic              char_valid, char_ferr, char_perr, char_brk;
    logic [DATA_W-1:0] char_data;
    logic              ovr_pend;
    logic              wr_en;
    rx_entry_t         entry;

    rxq_sync #(.STAGES(2)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rx_in),
        .dout  (line_s)
    );

    rxq_frame_fsm #(.OS_MAX(OS_MAX)) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line       (line_s),
        .tick       (os_tick),
        .fast_mode  (fast_mode),
        .word_sel   (word_sel),
        .par_en     (par_en),
        .par_odd    (par_odd),
        .char_valid (char_valid),
        .char_data  (char_data),
        .char_ferr  (char_ferr),
        .char_perr  (char_perr),
        .char_brk   (char_brk)
    );

    assign entry = '{ovr: ovr_pend, brk: char_brk, perr: char_perr,
                     ferr: char_ferr, data: char_data};
    assign wr_en = char_valid && !rx_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      ovr_pend <= 1'b0;
        else if (char_valid && rx_full)  ovr_pend <= 1'b1;
        else if (wr_en)                  ovr_pend <= 1'b0;
    end

    rxq_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) fifo_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (entry),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .empty   (rx_empty),
        .full    (rx_full)
    );

    // R9
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_valid && rx_full) |=> ovr_pend);

    // R9
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ovr_pend) |=> !ovr_pend);
endmodule

// File: tb/uart_rx_statq_tb_top.sv
module uart_rx_statq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_in = 1'b1;
    logic        fast_mode = 1'b0;
    logic [1:0]  word_sel = 2'd3;
    logic        par_en = 1'b0;
    logic        par_odd = 1'b0;
    logic        rd_en = 1'b0;
    logic        os_tick;
    logic [11:0] rd_data;
    logic        rx_empty, rx_full;
    logic [1:0]  tdiv = 2'd0;
    int          errs = 0;
    int          checks = 0;

    always #5 clk = ~clk;
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign os_tick = (tdiv == 2'd3);

    uart_rx_statq dut_i (
        .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .os_tick(os_tick),
        .fast_mode(fast_mode), .word_sel(word_sel), .par_en(par_en),
        .par_odd(par_odd), .rd_en(rd_en), .rd_data(rd_data),
        .rx_empty(rx_empty), .rx_full(rx_full)
    );

    task automatic chk_eq(string req, logic [11:0] act, logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%03h expected=%03h", req, act, exp);
        end
    endtask

    task automatic tick_wait(int n);
        repeat (n) @(posedge clk iff os_tick);
        #1;
    endtask

    task automatic drive_bit(logic b, bit narrow);
        int os = fast_mode ? 8 : 16;
        for (int t = 1; t <= os; t++) begin
            rx_in = (narrow && (t < os/2 - 1 || t > os/2 + 1)) ? ~b : b;
            tick_wait(1);
        end
    endtask

    function automatic logic [7:0] mask_data(logic [7:0] d, int n);
        return d & 8'((1 << n) - 1);
    endfunction

    function automatic logic par_bit(logic [7:0] d, int n, logic odd, bit flip);
        return (^mask_data(d, n)) ^ odd ^ flip;
    endfunction

    function automatic logic [11:0] exp_word(logic [7:0] d, int n, logic pe, logic odd,
                                             bit flip, bit stop, bit ovr);
        logic [7:0] m   = mask_data(d, n);
        logic       pb  = par_bit(d, n, odd, flip);
        logic       brk = (m == 8'd0) && (!pe || !pb) && !stop;
        return {ovr, brk, pe & flip, ~stop, m};
    endfunction

    task automatic send_frame(logic [7:0] d, bit narrow, bit flip, bit stop);
        int n = 5 + int'(word_sel);
        drive_bit(1'b0, 0);
        for (int i = 0; i < n; i++) drive_bit(d[i], narrow);
        if (par_en) drive_bit(par_bit(d, n, par_odd, flip), 0);
        drive_bit(stop, 0);
        rx_in = 1'b1;
        tick_wait(2);
    endtask

    task automatic pop_check(string req, logic [11:0] exp);
        @(negedge clk);
        chk_eq({req, " not-empty"}, {11'd0, rx_empty}, 12'd0);
        chk_eq(req, rd_data, exp);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk_eq("R10 empty", {11'd0, rx_empty}, 12'd1);
        chk_eq("R10 full", {11'd0, rx_full}, 12'd0);

        // R1 idle line stores nothing
        tick_wait(100);
        @(negedge clk);
        chk_eq("R1 idle empty", {11'd0, rx_empty}, 12'd1);

        // R8 basic 8N1 frame
        send_frame(8'hA5, 0, 0, 1);
        pop_check("R8 basic", 12'h0A5);

        // R3 narrow frames, 16x then 8x
        send_frame(8'h3C, 1, 0, 1);
        pop_check("R3 narrow 16x", 12'h03C);
        fast_mode = 1'b1;
        send_frame(8'hC3, 1, 0, 1);
        pop_check("R3 narrow 8x", 12'h0C3);
        fast_mode = 1'b0;

        // R4 word lengths
        word_sel = 2'd0;
        send_frame(8'hFF, 0, 0, 1);
        pop_check("R4 five bits", 12'h01F);
        word_sel = 2'd2;
        send_frame(8'hD5, 0, 0, 1);
        pop_check("R4 seven bits", 12'h055);
        word_sel = 2'd3;

        // R5 parity
        par_en = 1'b1; par_odd = 1'b1;
        send_frame(8'h5A, 0, 0, 1);
        pop_check("R5 odd ok", 12'h05A);
        send_frame(8'h5A, 0, 1, 1);
        pop_check("R5 odd bad", 12'h25A);
        par_odd = 1'b0;
        send_frame(8'h81, 0, 1, 1);
        pop_check("R5 even bad", 12'h281);
        par_en = 1'b0;

        // R6 framing error and recovery
        send_frame(8'h11, 0, 0, 0);
        pop_check("R6 framing", 12'h111);
        send_frame(8'h22, 0, 0, 1);
        pop_check("R6 recovery", 12'h022);

        // R7 break
        send_frame(8'h00, 0, 0, 0);
        pop_check("R7 break", 12'h500);

        // R2 glitch on start bit
        rx_in = 1'b0;
        tick_wait(2);
        rx_in = 1'b1;
        tick_wait(40);
        @(negedge clk);
        chk_eq("R2 glitch empty", {11'd0, rx_empty}, 12'd1);
        send_frame(8'h77, 0, 0, 1);
        pop_check("R2 after glitch", 12'h077);

        // R9 overrun
        fast_mode = 1'b1;
        for (int i = 0; i < 16; i++) send_frame(8'(8'h10 + i), 0, 0, 1);
        @(negedge clk);
        chk_eq("R8 full flag", {11'd0, rx_full}, 12'd1);
        send_frame(8'hEE, 0, 0, 1);
        @(negedge clk);
        chk_eq("R9 still full", {11'd0, rx_full}, 12'd1);
        chk_eq("R9 head kept", rd_data, 12'h010);
        pop_check("R9 pop head", 12'h010);
        send_frame(8'h99, 0, 0, 1);
        for (int i = 1; i < 16; i++) pop_check("R9 drain", 12'(12'h010 + i));
        pop_check("R9 overrun flag", 12'h899);
        @(negedge clk);
        chk_eq("R8 drained empty", {11'd0, rx_empty}, 12'd1);

        // random frames
        for (int k = 0; k < 24; k++) begin
            logic [7:0] d = 8'($urandom);
            bit flip = ($urandom % 6) == 0;
            bit stop = ($urandom % 7) != 0;
            fast_mode = 1'($urandom);
            word_sel  = 2'($urandom);
            par_en    = 1'($urandom);
            par_odd   = 1'($urandom);
            send_frame(d, 0, flip, stop);
            pop_check("R3 R4 R5 R6 random",
                      exp_word(d, 5 + int'(word_sel), par_en, par_odd, flip, stop, 0));
        end

        finish_run();
    end
endmodule